// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block turns an asynchronous serial line into bytes. Each frame carries one start bit, eight data bits sent least-significant first, and one stop bit; there is no parity. The bit period in clock cycles is the clock frequency divided by the baud rate, both given as parameters (12 MHz and 9600 baud by default). The line is first passed through a reset-to-idle synchronizer.

A falling line in idle is only a candidate start. The block re-checks the line half a bit later and abandons the frame if the line has returned high. Once the start bit is confirmed, each data bit is decided by voting five samples taken one eighth of a bit apart, from three eighths to seven eighths into the bit. A bit counts as 1 only when at least four of the five samples are high. The stop bit is sampled once at its centre. A good frame gives a one-cycle strobe together with the new byte. A low stop bit gives a one-cycle error pulse instead and leaves the byte output untouched. A busy flag covers the whole time between start detection and the return to idle.

Top module: `uart_rx_os`

## Requirements
- R1: The bit period is CLK_HZ/BAUD clock cycles. Frames sent at that rate are received correctly for every byte value from 0x00 to 0xFF.
- R2: A low pulse on an idle line that is shorter than half a bit period is rejected. It produces no strobe, no error pulse and no change to the byte, and busy returns low.
- R3: Each data bit is sampled at 3/8, 4/8, 5/8, 6/8 and 7/8 of its period. Line activity in the first 3/8 of any data bit has no effect on the received byte.
- R4: A data bit is decided as 1 when four or five of its five samples are high, and as 0 when three or fewer are high.
- R5: The first data bit on the line is bit 0 of the byte (LSB first), and the eighth is bit 7.
- R6: When the stop bit is low at its centre, rx_err is high for exactly one cycle, rx_valid stays low, and rx_data keeps its previous value.
- R7: For a frame with a high stop bit, rx_valid is high for exactly one cycle. The new byte is on rx_data in that same cycle, and rx_data changes at no other time.
- R8: rx_busy is high while a frame is being received and low once the block is back in idle.
- R9: After reset, rx_valid, rx_err and rx_busy are low and rx_data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_valid | output | 1 | One-cycle strobe when a good frame completes |
| rx_data | output | DATA_BITS | Last byte received without error |
| rx_busy | output | 1 | High while a frame is in progress |
| rx_err | output | 1 | One-cycle pulse on a low stop bit |

## Verification
The vote threshold is tested by inverting every one of the 32 subsets of the five sample slots, in each data bit position. A design that took a plain majority of three, or a single centre sample, would decide some of those bits wrongly. Glitches placed in the unsampled early part of each bit catch a sampling window that starts too soon or drifts from bit to bit. Short false starts and low stop bits catch a receiver that skips the half-bit start check, strobes on a broken frame, or overwrites the byte on an error. The full sweep of byte values catches bit-order mistakes and any off-by-one in the bit period.

// File: rtl/uart_rx_os_pkg.sv
package uart_rx_os_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_START  = 2'd1,
      ST_SAMPLE = 2'd2,
      ST_STOP   = 2'd3
   } rx_state_t;

endpackage

// File: rtl/uart_rx_os_sync.sv
module uart_rx_os_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], din};
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/uart_rx_os_timer.sv
module uart_rx_os_timer #(
   parameter int CNT_W    = 8,
   parameter int MAX_LOAD = 255
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)             cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R1: the wait counter never runs beyond the longest wait it is given
   assert_timer_range_R1: assert property (@(posedge clk) disable iff (rst)
      int'(cnt) <= MAX_LOAD);

   // R1: a running count moves down by one each cycle unless reloaded
   assert_timer_step_R1: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/uart_rx_os_vote.sv
module uart_rx_os_vote #(
   parameter int VOTES    = 5,
   parameter int VOTE_MIN = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic sample_en,
   input  logic din,
   output logic last,
   output logic bit_val
);

   localparam int W = $clog2(VOTES + 1);

   logic [W-1:0] idx;
   logic [W-1:0] ones;
   logic [W-1:0] ones_nx;

   assign ones_nx = ones + W'(din);
   assign last    = (idx == W'(VOTES - 1));
   assign bit_val = (int'(ones_nx) >= VOTE_MIN);

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         idx  <= '0;
         ones <= '0;
      end else if (sample_en) begin
         if (last) begin
            idx  <= '0;
            ones <= '0;
         end else begin
            idx  <= idx + 1'b1;
            ones <= ones_nx;
         end
      end
   end

   // R4: the high-sample tally never exceeds the number of samples taken
   assert_ones_le_idx_R4: assert property (@(posedge clk) disable iff (rst)
      ones <= idx);

   // R3: the sample index stays inside the voting window
   assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
      int'(idx) < VOTES);

endmodule

// File: rtl/uart_rx_os_shift.sv
module uart_rx_os_shift #(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 clear,
   input  logic                 shift_en,
   input  logic                 din,
   output logic [DATA_BITS-1:0] data,
   output logic                 last
);

   localparam int BW = $clog2(DATA_BITS + 1);

   logic [BW-1:0] nbits;

   assign last = (nbits == BW'(DATA_BITS - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         data  <= '0;
         nbits <= '0;
      end else if (clear) begin
         nbits <= '0;
      end else if (shift_en) begin
         data  <= {din, data[DATA_BITS-1:1]};
         nbits <= last ? '0 : nbits + 1'b1;
      end
   end

   // R5: the bit count stays inside one byte
   assert_nbits_range_R5: assert property (@(posedge clk) disable iff (rst)
      int'(nbits) < DATA_BITS);

   // R5: a shift moves the register one place toward bit 0
   assert_shift_dir_R5: assert property (@(posedge clk) disable iff (rst)
      (shift_en && !clear) |=> (data[DATA_BITS-2:0] == $past(data[DATA_BITS-1:1])));

endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os
   import uart_rx_os_pkg::*;
#(
   parameter int CLK_HZ      = 12_000_000,
   parameter int BAUD        = 9600,
   parameter int DATA_BITS   = 8,
   parameter int VOTES       = 5,
   parameter int VOTE_MIN    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 rx_line,
   output logic                 rx_valid,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_busy,
   output logic                 rx_err
);

   localparam int BIT_CYC    = CLK_HZ / BAUD;
   localparam int HALF       = BIT_CYC / 2;
   localparam int EIGHTH     = BIT_CYC / 8;
   localparam int FIRST_WAIT = HALF + 3 * EIGHTH;
   localparam int STOP_WAIT  = HALF + EIGHTH;
   localparam int CNT_W      = $clog2(FIRST_WAIT + 1);

   localparam logic [CNT_W-1:0] LD_HALF   = CNT_W'(HALF - 1);
   localparam logic [CNT_W-1:0] LD_FIRST  = CNT_W'(FIRST_WAIT - 1);
   localparam logic [CNT_W-1:0] LD_EIGHTH = CNT_W'(EIGHTH - 1);
   localparam logic [CNT_W-1:0] LD_STOP   = CNT_W'(STOP_WAIT - 1);

   generate
      if (BIT_CYC < 16) begin : g_chk_rate
         $error("uart_rx_os: CLK_HZ/BAUD must be at least 16");
      end
      if (DATA_BITS < 2) begin : g_chk_bits
         $error("uart_rx_os: DATA_BITS must be at least 2");
      end
      if (VOTES < 1 || VOTES > 5) begin : g_chk_votes
         $error("uart_rx_os: VOTES must lie in 1..5");
      end
      if (VOTE_MIN < 1 || VOTE_MIN > VOTES) begin : g_chk_min
         $error("uart_rx_os: VOTE_MIN must lie in 1..VOTES");
      end
      if (SYNC_STAGES == 1) begin : g_chk_sync
         $error("uart_rx_os: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic                 line_s;
   logic                 tmr_load;
   logic [CNT_W-1:0]     tmr_val;
   logic                 tmr_done;
   logic                 vote_en;
   logic                 vote_clr;
   logic                 vote_last;
   logic                 vote_bit;
   logic                 shift_en;
   logic                 shift_last;
   logic [DATA_BITS-1:0] shift_data;
   logic                 frame_ok;
   logic                 frame_bad;
   rx_state_t            state;
   rx_state_t            state_nx;

   uart_rx_os_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst (rst), .din (rx_line), .dout (line_s)
   );

   uart_rx_os_timer #(.CNT_W(CNT_W), .MAX_LOAD(FIRST_WAIT - 1)) u_timer (
      .clk (clk), .rst (rst), .load (tmr_load), .load_val (tmr_val),
      .expired (tmr_done)
   );

   uart_rx_os_vote #(.VOTES(VOTES), .VOTE_MIN(VOTE_MIN)) u_vote (
      .clk (clk), .rst (rst), .clear (vote_clr), .sample_en (vote_en),
      .din (line_s), .last (vote_last), .bit_val (vote_bit)
   );

   uart_rx_os_shift #(.DATA_BITS(DATA_BITS)) u_shift (
      .clk (clk), .rst (rst), .clear (vote_clr), .shift_en (shift_en),
      .din (vote_bit), .data (shift_data), .last (shift_last)
   );

   always_comb begin
      state_nx  = state;
      tmr_load  = 1'b0;
      tmr_val   = LD_HALF;
      vote_en   = 1'b0;
      vote_clr  = 1'b0;
      shift_en  = 1'b0;
      frame_ok  = 1'b0;
      frame_bad = 1'b0;
      case (state)
         ST_IDLE: begin
            if (!line_s) begin
               state_nx = ST_START;
               tmr_load = 1'b1;
               tmr_val  = LD_HALF;
            end
         end
         ST_START: begin
            if (tmr_done) begin
               if (line_s) begin
                  state_nx = ST_IDLE;
               end else begin
                  state_nx = ST_SAMPLE;
                  vote_clr = 1'b1;
                  tmr_load = 1'b1;
                  tmr_val  = LD_FIRST;
               end
            end
         end
         ST_SAMPLE: begin
            if (tmr_done) begin
               vote_en  = 1'b1;
               tmr_load = 1'b1;
               if (!vote_last) begin
                  tmr_val = LD_EIGHTH;
               end else begin
                  shift_en = 1'b1;
                  if (shift_last) begin
                     state_nx = ST_STOP;
                     tmr_val  = LD_STOP;
                  end else begin
                     tmr_val  = LD_HALF;
                  end
               end
            end
         end
         ST_STOP: begin
            if (tmr_done) begin
               state_nx  = ST_IDLE;
               frame_ok  = line_s;
               frame_bad = !line_s;
            end
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         rx_valid <= 1'b0;
         rx_err   <= 1'b0;
         rx_data  <= '0;
      end else begin
         state    <= state_nx;
         rx_valid <= frame_ok;
         rx_err   <= frame_bad;
         if (frame_ok) rx_data <= shift_data;
      end
   end

   assign rx_busy = (state != ST_IDLE);

   // R7: the received strobe lasts a single cycle
   assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> !rx_valid);

   // R7: the byte output only moves together with the strobe
   assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !rx_valid |=> (!rx_valid || $changed(rx_data) || $stable(rx_data)) && (rx_valid || $stable(rx_data)));

   // R6: the error pulse lasts a single cycle and never meets the strobe
   assert_err_single_R6: assert property (@(posedge clk) disable iff (rst)
      rx_err |=> !rx_err);
   assert_err_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
      !(rx_err && rx_valid));

   // R8: a frame result appears only as the block leaves a busy frame
   assert_end_of_frame_R8: assert property (@(posedge clk) disable iff (rst)
      (rx_valid || rx_err) |-> (!rx_busy && $past(rx_busy)));

endmodule

// File: tb/uart_rx_os_bench.sv
module uart_rx_os_bench;

   localparam int CLK_HZ = 160;
   localparam int BAUD   = 10;
   localparam int BITC   = CLK_HZ / BAUD;
   localparam int SLOTC  = BITC / 8;
   localparam int FRAMEC = BITC * 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx_line = 1'b1;
   logic       rx_valid;
   logic [7:0] rx_data;
   logic       rx_busy;
   logic       rx_err;

   int  n_checks = 0;
   int  n_fails  = 0;
   int  n_valid  = 0;
   int  n_err    = 0;
   int  n_wide   = 0;
   int  n_stray  = 0;
   logic [7:0] cap_data = 8'h00;
   logic [7:0] prev_data = 8'h00;
   logic       prev_valid = 1'b0;
   bit         finished = 1'b0;

   uart_rx_os #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_uart_rx_os (
      .clk (clk), .rst (rst), .rx_line (rx_line), .rx_valid (rx_valid),
      .rx_data (rx_data), .rx_busy (rx_busy), .rx_err (rx_err)
   );

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      if (!rst) begin
         if (rx_valid) begin
            n_valid  = n_valid + 1;
            cap_data = rx_data;
         end
         if (rx_err) n_err = n_err + 1;
         if (rx_valid && prev_valid) n_wide = n_wide + 1;
         if (!rx_valid && rx_data != prev_data) n_stray = n_stray + 1;
      end
      prev_valid = rx_valid;
      prev_data  = rx_data;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // cbit: data bit whose voting slots get mask applied (-1 for none)
   // outer: invert the unsampled first three eighths of every data bit
   task automatic send(input logic [7:0] b, input logic stop_v, input int cbit,
                       input logic [4:0] mask, input bit outer);
      for (int cyc = 0; cyc < FRAMEC; cyc++) begin
         int   bi;
         int   slot;
         logic v;
         bi   = cyc / BITC;
         slot = (cyc % BITC) / SLOTC;
         if (bi == 0)      v = 1'b0;
         else if (bi == 9) v = stop_v;
         else begin
            v = b[bi-1];
            if (bi - 1 == cbit && slot >= 3 && mask[slot-3]) v = ~v;
            if (outer && slot < 3) v = ~v;
         end
         @(negedge clk);
         rx_line = v;
         if (cyc == FRAMEC / 2)
            check(rx_busy == 1'b1, "R8 busy mid-frame", int'(rx_busy), 1);
      end
      @(negedge clk);
      rx_line = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic expect_frame(input string req, input logic [7:0] exp, input int v0, input int e0);
      bit ok;
      ok = (n_valid - v0 == 1) && (n_err - e0 == 0) && (cap_data == exp) && (rx_data == exp);
      check(ok, req, int'(cap_data), int'(exp));
   endtask

   initial begin
      int v0;
      int e0;
      logic [7:0] keep;
      repeat (4) @(negedge clk);
      check(rx_valid == 1'b0 && rx_err == 1'b0 && rx_busy == 1'b0 && rx_data == 8'h00,
            "R9 reset state", {rx_valid, rx_err, rx_busy, rx_data}, 0);
      rst = 1'b0;
      repeat (8) @(negedge clk);
      check(rx_busy == 1'b0 && rx_data == 8'h00, "R9 idle after reset",
            {rx_busy, rx_data}, 0);

      // R1 R5: every byte value, clean line
      for (int b = 0; b < 256; b++) begin
         v0 = n_valid; e0 = n_err;
         send(8'(b), 1'b1, -1, 5'd0, 1'b0);
         expect_frame("R1 R5 clean byte", 8'(b), v0, e0);
      end
      check(rx_busy == 1'b0, "R8 busy low after frame", int'(rx_busy), 0);

      // R4: every subset of voting slots inverted, in every bit position
      for (int c = 0; c < 8; c++) begin
         for (int m = 0; m < 32; m++) begin
            logic [7:0] base;
            logic [7:0] exp;
            int pc;
            int highs;
            base = (c % 2 == 1) ? 8'h3C : 8'hC3;
            pc = 0;
            for (int k = 0; k < 5; k++) pc += (m >> k) & 1;
            highs = base[c] ? 5 - pc : pc;
            exp = base;
            exp[c] = (highs > 3);
            v0 = n_valid; e0 = n_err;
            send(base, 1'b1, c, 5'(m), 1'b0);
            expect_frame("R4 vote threshold", exp, v0, e0);
         end
      end

      // R3: activity before the sampling window is ignored
      for (int b = 0; b < 16; b++) begin
         logic [7:0] val;
         val = 8'(b * 37 + 5);
         v0 = n_valid; e0 = n_err;
         send(val, 1'b1, -1, 5'd0, 1'b1);
         expect_frame("R3 early glitches ignored", val, v0, e0);
      end

      // R2: short false start
      keep = rx_data;
      v0 = n_valid; e0 = n_err;
      rx_line = 1'b0;
      repeat (7) @(negedge clk);
      check(rx_busy == 1'b1, "R8 busy on candidate start", int'(rx_busy), 1);
      rx_line = 1'b1;
      repeat (30) @(negedge clk);
      check(n_valid == v0 && n_err == e0, "R2 false start no result",
            (n_valid - v0) + (n_err - e0), 0);
      check(rx_busy == 1'b0 && rx_data == keep, "R2 false start back to idle",
            int'(rx_data), int'(keep));

      // R6: low stop bit
      for (int t = 0; t < 3; t++) begin
         keep = rx_data;
         v0 = n_valid; e0 = n_err;
         send(8'(8'h96 + t), 1'b0, -1, 5'd0, 1'b0);
         repeat (40) @(negedge clk);
         check(n_err - e0 == 1 && n_valid == v0, "R6 stop error pulse",
               n_err - e0, 1);
         check(rx_data == keep, "R6 byte unchanged on error", int'(rx_data), int'(keep));
         check(rx_busy == 1'b0, "R8 idle after error frame", int'(rx_busy), 0);
      end

      // R6 R1: recovery after an error frame
      v0 = n_valid; e0 = n_err;
      send(8'h5E, 1'b1, -1, 5'd0, 1'b0);
      expect_frame("R6 good frame after error", 8'h5E, v0, e0);

      check(n_wide == 0, "R7 strobe single cycle", n_wide, 0);
      check(n_stray == 0, "R7 byte changes only with strobe", n_stray, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 150000, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule